// File: doc/BRIEF.md
# LCD panel timing generator

This block drives the control signals of a parallel LCD panel: a horizontal sync, a vertical sync and a data-enable. It also raises a pixel-request strobe toward the pixel source in every active pixel slot. All timing values come from registers written through a single-cycle write port. Horizontal timing is expressed in pixels. Vertical timing is expressed as absolute pixel-clock counts from the start of the frame, so a vertical edge can fall at any pixel and not only on a line boundary.

Inside the active window the block forwards the pixel source's data. When the source fails to deliver and recovery is enabled, it substitutes a programmable underflow colour. Outside the active window it drives a programmable border colour. A one-cycle frame-start pulse marks each frame boundary, so software can see when a change to the enable or to the timing has taken effect. Everything runs on the pixel clock.

Top module: `lcd_tg_top`

## Requirements
- R1: After reset the block is idle: hsync_o, vsync_o, de_o, pix_req_o and frame_start_o are 0, and pix_o is 0.
- R2: While running, a line counter counts 0..htotal-1. hsync is active while the line counter is below the pulse width.
- R3: A frame counter counts 0..period-1 in pixel clocks. At its wrap both counters return to 0. frame_start_o is high exactly in the cycles where the frame counter is 0 while running.
- R4: vsync is active while skew <= frame counter < skew + vsync length.
- R5: de_o is high when hstart <= line counter <= hend and vstart <= frame counter <= vend, both bounds inclusive. pix_req_o equals de_o.
- R6: Polarity register bit 0 inverts hsync_o and bit 1 inverts vsync_o, both in and out of the pulse. When the block is idle the syncs sit at their inactive level.
- R7: Setting the enable while idle starts a frame with both counters at 0 on the second clock edge after the write. Clearing it while running lets the current frame finish, and the block goes idle at the frame wrap.
- R8: Outside de_o, pix_o carries the border colour.
- R9: Inside de_o, pix_o is pix_i when pix_valid_i is 1. When pix_valid_i is 0, pix_o is the underflow colour if recovery is set, and pix_i otherwise.
- R10: Timing, polarity and colour registers are double-buffered. A write made while running takes effect at the next frame start. While idle they are loaded every cycle.
- R11: Register map (wr_addr_i): 0 enable [0]; 1 htotal [11:0] and hsync width [27:16]; 2 hstart [11:0] and hend [27:16]; 3 frame period [23:0]; 4 vsync length [23:0]; 5 vstart [23:0]; 6 vend [23:0]; 7 skew [23:0]; 8 polarity (bit 0 hsync active-low, bit 1 vsync active-low); 9 border colour [23:0]; 10 underflow colour [23:0] with recovery enable at bit 31. Other addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register index |
| wr_data_i | input | 32 | Register write data |
| pix_i | input | 24 | Pixel from the pixel source |
| pix_valid_i | input | 1 | pix_i holds a valid pixel this cycle |
| pix_req_o | output | 1 | Pixel request toward the source |
| pix_o | output | 24 | Pixel toward the panel |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| frame_start_o | output | 1 | One cycle at each frame start |

## Verification
A line counter that drifts shifts the hsync pulse and the horizontal window within the same line. The bench sees this in the first cycle that disagrees with the model. A frame counter wrapping at the wrong count moves frame_start_o, and every output then falls out of step from the next frame onward. A shadow register loaded mid-frame, or an enable that latches early, changes the sync widths, colours or idle level before the boundary. The scoreboard compares every pixel slot, so each of these errors shows within one frame.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  localparam int REG_CTRL   = 0;
  localparam int REG_HTIME  = 1;
  localparam int REG_HWIN   = 2;
  localparam int REG_PERIOD = 3;
  localparam int REG_VLEN   = 4;
  localparam int REG_VSTART = 5;
  localparam int REG_VEND   = 6;
  localparam int REG_SKEW   = 7;
  localparam int REG_POL    = 8;
  localparam int REG_BORDER = 9;
  localparam int REG_UFLOW  = 10;
  localparam int N_REGS     = 11;

  localparam int POL_HS = 0;
  localparam int POL_VS = 1;
endpackage

// File: rtl/lcd_tg_regs.sv
module lcd_tg_regs import lcd_tg_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int H_W    = 12,
  parameter int F_W    = 24,
  parameter int COL_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              load_i,
  output logic              run_o,
  output logic [H_W-1:0]    htot_o,
  output logic [H_W-1:0]    hpw_o,
  output logic [H_W-1:0]    hst_o,
  output logic [H_W-1:0]    hend_o,
  output logic [F_W-1:0]    period_o,
  output logic [F_W-1:0]    vlen_o,
  output logic [F_W-1:0]    vst_o,
  output logic [F_W-1:0]    vend_o,
  output logic [F_W-1:0]    skew_o,
  output logic [1:0]        pol_o,
  output logic [COL_W-1:0]  border_o,
  output logic [COL_W-1:0]  ucol_o,
  output logic              urec_o
);
  localparam int HF = DATA_W / 2;

  logic              st_en;
  logic [H_W-1:0]    st_htot, st_hpw, st_hst, st_hend;
  logic [F_W-1:0]    st_period, st_vlen, st_vst, st_vend, st_skew;
  logic [1:0]        st_pol;
  logic [COL_W-1:0]  st_border, st_ucol;
  logic              st_urec;

  logic unused_wdata;
  assign unused_wdata = ^wr_data_i;

  // staging copy, written by software at any time
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_en <= 1'b0;
      st_htot <= '0; st_hpw <= '0; st_hst <= '0; st_hend <= '0;
      st_period <= '0; st_vlen <= '0; st_vst <= '0; st_vend <= '0; st_skew <= '0;
      st_pol <= '0; st_border <= '0; st_ucol <= '0; st_urec <= 1'b0;
    end else if (wr_en_i) begin
      case (int'(wr_addr_i))
        REG_CTRL:   st_en <= wr_data_i[0];
        REG_HTIME:  begin st_htot <= wr_data_i[0 +: H_W]; st_hpw <= wr_data_i[HF +: H_W]; end
        REG_HWIN:   begin st_hst <= wr_data_i[0 +: H_W]; st_hend <= wr_data_i[HF +: H_W]; end
        REG_PERIOD: st_period <= wr_data_i[0 +: F_W];
        REG_VLEN:   st_vlen <= wr_data_i[0 +: F_W];
        REG_VSTART: st_vst <= wr_data_i[0 +: F_W];
        REG_VEND:   st_vend <= wr_data_i[0 +: F_W];
        REG_SKEW:   st_skew <= wr_data_i[0 +: F_W];
        REG_POL:    st_pol <= wr_data_i[1:0];
        REG_BORDER: st_border <= wr_data_i[0 +: COL_W];
        REG_UFLOW:  begin st_ucol <= wr_data_i[0 +: COL_W]; st_urec <= wr_data_i[DATA_W-1]; end
        default: ;
      endcase
    end
  end

  // active copy, loaded only at a frame boundary or while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o <= 1'b0;
      htot_o <= '0; hpw_o <= '0; hst_o <= '0; hend_o <= '0;
      period_o <= '0; vlen_o <= '0; vst_o <= '0; vend_o <= '0; skew_o <= '0;
      pol_o <= '0; border_o <= '0; ucol_o <= '0; urec_o <= 1'b0;
    end else if (load_i) begin
      run_o <= st_en;
      htot_o <= st_htot; hpw_o <= st_hpw; hst_o <= st_hst; hend_o <= st_hend;
      period_o <= st_period; vlen_o <= st_vlen; vst_o <= st_vst; vend_o <= st_vend;
      skew_o <= st_skew; pol_o <= st_pol; border_o <= st_border;
      ucol_o <= st_ucol; urec_o <= st_urec;
    end
  end

  // R7: run state only changes at a load point
  assert_run_at_boundary_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(run_o) |-> $past(load_i));

  // R10: the active timing stays fixed inside a frame
  assert_shadow_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(period_o) && $stable(htot_o) && $stable(pol_o)));
endmodule

// File: rtl/lcd_tg_count.sv
module lcd_tg_count #(
  parameter int H_W = 12,
  parameter int F_W = 24
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic [H_W-1:0] htot_i,
  input  logic [F_W-1:0] period_i,
  output logic [H_W-1:0] hcnt_o,
  output logic [F_W-1:0] fcnt_o,
  output logic           load_o
);
  logic frame_end, line_end;

  assign frame_end = (fcnt_o == period_i - F_W'(1));
  assign line_end  = (hcnt_o == htot_i - H_W'(1));
  assign load_o    = !run_i || frame_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_o <= '0;
      fcnt_o <= '0;
    end else if (load_o) begin
      hcnt_o <= '0;
      fcnt_o <= '0;
    end else begin
      fcnt_o <= fcnt_o + F_W'(1);
      hcnt_o <= line_end ? '0 : hcnt_o + H_W'(1);
    end
  end

  assert_hcnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && htot_i != '0) |-> (hcnt_o < htot_i));

  assert_frame_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && fcnt_o == '0) |-> ($past(fcnt_o) == $past(period_i) - F_W'(1)));
endmodule

// File: rtl/lcd_tg_out.sv
module lcd_tg_out import lcd_tg_pkg::*; #(
  parameter int H_W   = 12,
  parameter int F_W   = 24,
  parameter int COL_W = 24
) (
  input  logic             run_i,
  input  logic [H_W-1:0]   hcnt_i,
  input  logic [F_W-1:0]   fcnt_i,
  input  logic [H_W-1:0]   hpw_i,
  input  logic [H_W-1:0]   hst_i,
  input  logic [H_W-1:0]   hend_i,
  input  logic [F_W-1:0]   vlen_i,
  input  logic [F_W-1:0]   vst_i,
  input  logic [F_W-1:0]   vend_i,
  input  logic [F_W-1:0]   skew_i,
  input  logic [1:0]       pol_i,
  input  logic [COL_W-1:0] border_i,
  input  logic [COL_W-1:0] ucol_i,
  input  logic             urec_i,
  input  logic [COL_W-1:0] pix_i,
  input  logic             pix_valid_i,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic             req_o,
  output logic             frame_start_o,
  output logic [COL_W-1:0] pix_o
);
  logic [F_W:0] vs_end;
  logic h_sync, v_sync, h_win, v_win;

  assign vs_end = {1'b0, skew_i} + {1'b0, vlen_i};
  assign h_sync = hcnt_i < hpw_i;
  assign v_sync = (fcnt_i >= skew_i) && ({1'b0, fcnt_i} < vs_end);
  assign h_win  = (hcnt_i >= hst_i) && (hcnt_i <= hend_i);
  assign v_win  = (fcnt_i >= vst_i) && (fcnt_i <= vend_i);

  assign de_o          = run_i && h_win && v_win;
  assign req_o         = de_o;
  assign hsync_o       = (run_i && h_sync) ^ pol_i[POL_HS];
  assign vsync_o       = (run_i && v_sync) ^ pol_i[POL_VS];
  assign frame_start_o = run_i && (fcnt_i == '0);

  always_comb begin
    if (!de_o)                    pix_o = border_i;
    else if (pix_valid_i || !urec_i) pix_o = pix_i;
    else                          pix_o = ucol_i;
  end
endmodule

// File: rtl/lcd_tg_top.sv
module lcd_tg_top #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int H_W    = 12,
  parameter int F_W    = 24,
  parameter int COL_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [COL_W-1:0]  pix_i,
  input  logic              pix_valid_i,
  output logic              pix_req_o,
  output logic [COL_W-1:0]  pix_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic              frame_start_o
);
  logic             run, load, urec;
  logic [H_W-1:0]   htot, hpw, hst, hend, hcnt;
  logic [F_W-1:0]   period, vlen, vst, vend, skew, fcnt;
  logic [1:0]       pol;
  logic [COL_W-1:0] border, ucol;

  lcd_tg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .H_W(H_W), .F_W(F_W), .COL_W(COL_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .load_i(load), .run_o(run),
    .htot_o(htot), .hpw_o(hpw), .hst_o(hst), .hend_o(hend),
    .period_o(period), .vlen_o(vlen), .vst_o(vst), .vend_o(vend), .skew_o(skew),
    .pol_o(pol), .border_o(border), .ucol_o(ucol), .urec_o(urec)
  );

  lcd_tg_count #(.H_W(H_W), .F_W(F_W)) u_count (
    .clk_i, .rst_ni, .run_i(run), .htot_i(htot), .period_i(period),
    .hcnt_o(hcnt), .fcnt_o(fcnt), .load_o(load)
  );

  lcd_tg_out #(.H_W(H_W), .F_W(F_W), .COL_W(COL_W)) u_out (
    .run_i(run), .hcnt_i(hcnt), .fcnt_i(fcnt),
    .hpw_i(hpw), .hst_i(hst), .hend_i(hend),
    .vlen_i(vlen), .vst_i(vst), .vend_i(vend), .skew_i(skew),
    .pol_i(pol), .border_i(border), .ucol_i(ucol), .urec_i(urec),
    .pix_i, .pix_valid_i,
    .hsync_o, .vsync_o, .de_o, .req_o(pix_req_o), .frame_start_o, .pix_o
  );
endmodule

// File: tb/test_lcd_tg_top.sv
module test_lcd_tg_top;
  typedef struct packed {
    logic        hs, vs, de, fs;
    logic [1:0]  pol;
    logic [23:0] border, ucol;
    logic        rec;
  } item_t;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [23:0] pix_i = '0;
  logic        pix_valid_i = 1'b0;
  logic        pix_req_o, hsync_o, vsync_o, de_o, frame_start_o;
  logic [23:0] pix_o;

  item_t q[$];
  logic  arm = 1'b0, done = 1'b0;
  int    checks = 0, fails = 0, cyc = 0;
  int    c_htot, c_hpw, c_hst, c_hend, c_per, c_vlen, c_vst, c_vend, c_skew, c_pol, c_rec;
  logic [23:0] c_border, c_ucol;

  always #2.5 clk = ~clk;

  lcd_tg_top i_lcd_tg_top (
    .clk_i(clk), .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .pix_i, .pix_valid_i,
    .pix_req_o, .pix_o, .hsync_o, .vsync_o, .de_o, .frame_start_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = 4'(addr); wr_data_i = data;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  // R11 register layout
  task automatic apply_cfg();
    wr(1, (32'(c_hpw) << 16) | 32'(c_htot));
    wr(2, (32'(c_hend) << 16) | 32'(c_hst));
    wr(3, 32'(c_per));
    wr(4, 32'(c_vlen));
    wr(5, 32'(c_vst));
    wr(6, 32'(c_vend));
    wr(7, 32'(c_skew));
    wr(8, 32'(c_pol));
    wr(9, {8'h0, c_border});
    wr(10, {c_rec[0], 7'h0, c_ucol});
  endtask

  task automatic push_frame();
    for (int t = 0; t < c_per; t++) begin
      item_t it;
      int h;
      h = t % c_htot;
      it.hs = (h < c_hpw);
      it.vs = (t >= c_skew) && (t < c_skew + c_vlen);
      it.de = (h >= c_hst) && (h <= c_hend) && (t >= c_vst) && (t <= c_vend);
      it.fs = (t == 0);
      it.pol = 2'(c_pol); it.border = c_border; it.ucol = c_ucol; it.rec = c_rec[0];
      q.push_back(it);
    end
  endtask

  task automatic push_idle(input int n);
    for (int i = 0; i < n; i++) begin
      item_t it;
      it = '0;
      it.pol = 2'(c_pol); it.border = c_border; it.ucol = c_ucol; it.rec = c_rec[0];
      q.push_back(it);
    end
  endtask

  // pixel source stimulus, changes just after each rising edge
  initial forever begin
    @(posedge clk); #1;
    cyc++;
    pix_i = 24'(cyc * 24'h010305);
    pix_valid_i = (cyc % 5) != 0;
  end

  // monitor: pops one expected item per pixel slot
  initial forever begin
    @(negedge clk);
    if (arm && q.size() > 0) begin
      item_t it;
      logic [23:0] ep;
      it = q.pop_front();
      if (!it.de) ep = it.border;
      else if (pix_valid_i || !it.rec) ep = pix_i;
      else ep = it.ucol;
      chk("R2,R6 hsync", 32'(hsync_o), 32'(it.hs ^ it.pol[0]));
      chk("R4,R6 vsync", 32'(vsync_o), 32'(it.vs ^ it.pol[1]));
      chk("R5 de", 32'(de_o), 32'(it.de));
      chk("R5 pix_req", 32'(pix_req_o), 32'(it.de));
      chk("R3 frame_start", 32'(frame_start_o), 32'(it.fs));
      chk(it.de ? "R9 pix" : "R8 pix", 32'(pix_o), 32'(ep));
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 hsync", 32'(hsync_o), 0);
    chk("R1 vsync", 32'(vsync_o), 0);
    chk("R1 de", 32'(de_o), 0);
    chk("R1 pix_req", 32'(pix_req_o), 0);
    chk("R1 frame_start", 32'(frame_start_o), 0);
    chk("R1 pix", 32'(pix_o), 0);

    // config A: skewed vsync, windows inside the frame, recovery on
    c_htot = 10; c_hpw = 2; c_hst = 3; c_hend = 8; c_per = 40; c_vlen = 10;
    c_vst = 12; c_vend = 31; c_skew = 2; c_pol = 0; c_rec = 1;
    c_border = 24'h102030; c_ucol = 24'h0000ff;
    apply_cfg();
    wr(0, 32'h1);            // R7 start from idle
    push_frame();
    @(posedge clk); arm = 1'b1;

    // R10: new timing written mid-frame applies at the next frame
    wait (q.size() <= 35);
    c_htot = 8; c_hpw = 3; c_hst = 1; c_hend = 6; c_per = 32; c_vlen = 16;
    c_vst = 16; c_vend = 31; c_skew = 0; c_pol = 3; c_rec = 0;
    c_border = 24'h0a0b0c; c_ucol = 24'h00ff00;
    apply_cfg();
    push_frame();
    push_frame();

    // R7: disable mid-frame, frame completes, then idle at inactive level
    wait (q.size() <= 20);
    wr(0, 32'h0);
    push_idle(10);
    wait (q.size() == 0);
    @(posedge clk); arm = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule